// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block performs automatic hardware handshaking for one serial channel. On the receive side it drives the active-low RTS pin from the receive buffer fill count. RTS goes off (high) once the fill reaches an upper mark. It comes back on (low) only after the fill has fallen to a lower mark, so the pin does not chatter around a single level. The receiver is expected to keep storing characters while RTS is off, until its buffer is full. This block does nothing to stop it.

On the transmit side the block brings the CTS pin in through a synchronizer. It then gates the transmitter with a transmit-allowed level. A stop request from the far end (CTS going high) never cuts a character short. The gate closes only at the transmitter's end-of-stop-bit strobe, or while the transmitter is idle. When CTS returns low, the gate reopens at the same kind of boundary. A rising CTS can also raise a sticky interrupt flag, which is cleared by an acknowledge pulse.

When automatic RTS is switched off, the RTS pin follows a software-driven level. When automatic CTS is switched off, the transmitter is never held back by CTS.

Top module: `hw_flow_ctl`

## Requirements
- R1: After reset, rtsN is 1, txAllowed is 1 and ctsIrq is 0.
- R2: With autoRtsEn=1, rtsN becomes 1 on the clock edge after rxFill is at or above the upper mark for trigSel. The upper marks are 8 for trigSel=0, 16 for 1, 24 for 2 and 28 for 3.
- R3: With autoRtsEn=1, rtsN becomes 0 on the clock edge after rxFill is at or below the lower mark for trigSel. The lower marks are 0 for trigSel=0, 7 for 1, 15 for 2 and 23 for 3.
- R4: With autoRtsEn=1 and rxFill strictly between the two marks, rtsN holds its previous value.
- R5: With autoRtsEn=0, rtsN equals the swRtsN value from the previous clock edge, and rxFill has no effect.
- R6: With autoCtsEn=1 and ctsN=1 while the transmitter is busy (txIdle=0), txAllowed stays 1 until a txStopDone pulse. On the edge that samples the pulse, txAllowed drops to 0.
- R7: While txIdle=1, txAllowed follows the two-stage synchronized CTS. It takes the new value on the third rising edge after ctsN changes, and not before.
- R8: After ctsN returns to 0, txAllowed returns to 1 at the next boundary (a txStopDone pulse, or txIdle=1). It stays 0 in between.
- R9: With autoCtsEn=0, txAllowed stays 1 whatever ctsN does, and a CTS rise does not set ctsIrq.
- R10: With autoCtsEn=1 and ctsIntEn=1, a 0-to-1 change of the synchronized CTS sets ctsIrq, which then stays 1 until a ctsIrqAck pulse clears it. With ctsIntEn=0 a CTS rise leaves ctsIrq at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| autoRtsEn | input | 1 | Enable automatic RTS from the fill level |
| autoCtsEn | input | 1 | Enable CTS gating of the transmitter |
| trigSel | input | 2 | Selects one pair of upper and lower fill marks |
| rxFill | input | FILL_W (6) | Receive buffer fill count |
| swRtsN | input | 1 | RTS pin level used when automatic RTS is off |
| ctsN | input | 1 | CTS pin, asynchronous; 1 means stop |
| txIdle | input | 1 | Transmitter has no character in flight |
| txStopDone | input | 1 | One-cycle pulse when a stop bit has been shifted out |
| ctsIntEn | input | 1 | Enable for the CTS-rise interrupt |
| ctsIrqAck | input | 1 | One-cycle pulse that clears ctsIrq |
| rtsN | output | 1 | RTS pin, active low |
| txAllowed | output | 1 | Transmitter may start or continue characters |
| ctsIrq | output | 1 | Sticky CTS-rise interrupt flag |

## Verification
The assertions assume three things about the inputs. txStopDone pulses only while a character is in flight. trigSel and the enables change only between checks. rxFill is a count no larger than the buffer depth, so the comparison against the selected marks is meaningful. The bench drives all inputs on the falling clock edge. It waits at least three edges after every ctsN change before it relies on the synchronized value. It holds ctsN low whenever a CTS rise should not count, which keeps stray interrupt events from spilling into later scenarios.

// File: rtl/hw_flow_pkg.sv
package hw_flow_pkg;

  typedef struct packed {
    logic ctsRise;   // synchronized CTS went 0 -> 1
    logic ctsLevel;  // synchronized CTS level (1 = stop)
    logic fillHigh;  // fill at or above the upper mark
    logic fillLow;   // fill at or below the lower mark
  } flowStrobe_t;

  function automatic int unsigned hiMark(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 24;
      default: return 28;
    endcase
  endfunction

  function automatic int unsigned loMark(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 7;
      2'd2:    return 15;
      default: return 23;
    endcase
  endfunction

endpackage

// File: rtl/hw_flow_dp.sv
module hw_flow_dp
  import hw_flow_pkg::*;
#(
  parameter int FILL_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctsN,
  input  logic [1:0]        trigSel,
  input  logic [FILL_W-1:0] rxFill,
  output flowStrobe_t       strb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   ctsPrev;
  logic                   ctsSync;

  // synchronizer chain; first stage takes the raw pin
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b0;
        else if (g == 0) syncChain[g] <= ctsN;
        else syncChain[g] <= syncChain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign ctsSync = syncChain[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctsPrev <= 1'b0;
    else       ctsPrev <= ctsSync;
  end

  always_comb begin
    strb.ctsRise  = ctsSync & ~ctsPrev;
    strb.ctsLevel = ctsSync;
    strb.fillHigh = 32'(rxFill) >= hiMark(trigSel);
    strb.fillLow  = 32'(rxFill) <= loMark(trigSel);
  end

endmodule

// File: rtl/hw_flow_ctrl.sv
module hw_flow_ctrl
  import hw_flow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  flowStrobe_t strb,
  input  logic        autoRtsEn,
  input  logic        autoCtsEn,
  input  logic        swRtsN,
  input  logic        txIdle,
  input  logic        txStopDone,
  input  logic        ctsIntEn,
  input  logic        ctsIrqAck,
  output logic        rtsN,
  output logic        txAllowed,
  output logic        ctsIrq
);

  logic rtsNext;
  logic atBoundary;
  logic ctsStop;
  logic irqSet;

  always_comb begin
    if (!autoRtsEn)        rtsNext = swRtsN;
    else if (strb.fillHigh) rtsNext = 1'b1;
    else if (strb.fillLow)  rtsNext = 1'b0;
    else                    rtsNext = rtsN;
  end

  assign atBoundary = txIdle | txStopDone;
  assign ctsStop    = autoCtsEn & strb.ctsLevel;
  assign irqSet     = strb.ctsRise & autoCtsEn & ctsIntEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtsN      <= 1'b1;
      txAllowed <= 1'b1;
      ctsIrq    <= 1'b0;
    end else begin
      rtsN <= rtsNext;
      if (atBoundary) txAllowed <= ~ctsStop;
      if (irqSet)         ctsIrq <= 1'b1;
      else if (ctsIrqAck) ctsIrq <= 1'b0;
    end
  end

endmodule

// File: rtl/hw_flow_ctl.sv
module hw_flow_ctl
  import hw_flow_pkg::*;
#(
  parameter int FILL_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              autoRtsEn,
  input  logic              autoCtsEn,
  input  logic [1:0]        trigSel,
  input  logic [FILL_W-1:0] rxFill,
  input  logic              swRtsN,
  input  logic              ctsN,
  input  logic              txIdle,
  input  logic              txStopDone,
  input  logic              ctsIntEn,
  input  logic              ctsIrqAck,
  output logic              rtsN,
  output logic              txAllowed,
  output logic              ctsIrq
);

  flowStrobe_t strb;

  hw_flow_dp #(.FILL_W(FILL_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .ctsN(ctsN), .trigSel(trigSel),
    .rxFill(rxFill), .strb(strb)
  );

  hw_flow_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strb(strb), .autoRtsEn(autoRtsEn),
    .autoCtsEn(autoCtsEn), .swRtsN(swRtsN), .txIdle(txIdle),
    .txStopDone(txStopDone), .ctsIntEn(ctsIntEn), .ctsIrqAck(ctsIrqAck),
    .rtsN(rtsN), .txAllowed(txAllowed), .ctsIrq(ctsIrq)
  );

endmodule

// File: rtl/hw_flow_chk.sv
module hw_flow_chk
  import hw_flow_pkg::*;
#(
  parameter int FILL_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              autoRtsEn,
  input logic              autoCtsEn,
  input logic [1:0]        trigSel,
  input logic [FILL_W-1:0] rxFill,
  input logic              swRtsN,
  input logic              txIdle,
  input logic              txStopDone,
  input logic              ctsIntEn,
  input logic              ctsIrqAck,
  input logic              rtsN,
  input logic              txAllowed,
  input logic              ctsIrq
);

  // R2
  rts_off_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rtsN) && $past(autoRtsEn)) |-> (32'($past(rxFill)) >= hiMark($past(trigSel))));

  // R3
  rts_on_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rtsN) && $past(autoRtsEn)) |-> (32'($past(rxFill)) <= loMark($past(trigSel))));

  // R5
  rts_sw_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!autoRtsEn) |-> (rtsN == $past(swRtsN)));

  // R6
  tx_gate_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txAllowed) |-> $past(txIdle || txStopDone));

  // R9
  tx_no_cts_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!autoCtsEn) && $past(txIdle || txStopDone)) |-> txAllowed);

  // R10
  irq_set_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctsIrq) |-> $past(autoCtsEn && ctsIntEn));

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctsIrq) |-> $past(ctsIrqAck));

endmodule

bind hw_flow_ctl hw_flow_chk #(.FILL_W(FILL_W)) u_chk (
  .clk(clk), .rstN(rstN), .autoRtsEn(autoRtsEn), .autoCtsEn(autoCtsEn),
  .trigSel(trigSel), .rxFill(rxFill), .swRtsN(swRtsN), .txIdle(txIdle),
  .txStopDone(txStopDone), .ctsIntEn(ctsIntEn), .ctsIrqAck(ctsIrqAck),
  .rtsN(rtsN), .txAllowed(txAllowed), .ctsIrq(ctsIrq)
);

// File: tb/sim_hw_flow_ctl.sv
`timescale 1ns/1ps
module sim_hw_flow_ctl;

  localparam int FILL_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoRtsEn = 1'b0, autoCtsEn = 1'b0;
  logic [1:0] trigSel = 2'd0;
  logic [FILL_W-1:0] rxFill = '0;
  logic swRtsN = 1'b1, ctsN = 1'b0, txIdle = 1'b1, txStopDone = 1'b0;
  logic ctsIntEn = 1'b0, ctsIrqAck = 1'b0;
  logic rtsN, txAllowed, ctsIrq;

  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  hw_flow_ctl #(.FILL_W(FILL_W)) u0 (
    .clk(clk), .rstN(rstN), .autoRtsEn(autoRtsEn), .autoCtsEn(autoCtsEn),
    .trigSel(trigSel), .rxFill(rxFill), .swRtsN(swRtsN), .ctsN(ctsN),
    .txIdle(txIdle), .txStopDone(txStopDone), .ctsIntEn(ctsIntEn),
    .ctsIrqAck(ctsIrqAck), .rtsN(rtsN), .txAllowed(txAllowed), .ctsIrq(ctsIrq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic pulseStop();
    txStopDone = 1'b1;
    tick(1);
    txStopDone = 1'b0;
  endtask

  task automatic testReset();
    check("R1 rtsN", rtsN, 1'b1);
    check("R1 txAllowed", txAllowed, 1'b1);
    check("R1 ctsIrq", ctsIrq, 1'b0);
  endtask

  task automatic testRtsMarks();
    int hi[4] = '{8, 16, 24, 28};
    int lo[4] = '{0, 7, 15, 23};
    autoRtsEn = 1'b1;
    for (int s = 0; s < 4; s++) begin
      trigSel = 2'(s);
      rxFill = '0; tick(1);
      check("R3 empty", rtsN, 1'b0);
      rxFill = FILL_W'(hi[s] - 1); tick(1);
      check("R4 below upper", rtsN, 1'b0);
      rxFill = FILL_W'(hi[s]); tick(1);
      check("R2 at upper", rtsN, 1'b1);
      rxFill = FILL_W'(lo[s] + 1); tick(1);
      check("R4 above lower", rtsN, 1'b1);
      rxFill = FILL_W'(lo[s]); tick(1);
      check("R3 at lower", rtsN, 1'b0);
    end
  endtask

  task automatic testRtsSoftware();
    autoRtsEn = 1'b0;
    swRtsN = 1'b1; rxFill = '0; tick(1);
    check("R5 sw high", rtsN, 1'b1);
    swRtsN = 1'b0; rxFill = 6'd32; tick(1);
    check("R5 sw low full", rtsN, 1'b0);
    autoRtsEn = 1'b1;
  endtask

  task automatic testCtsBusy();
    autoCtsEn = 1'b1; ctsIntEn = 1'b0; txIdle = 1'b0;
    ctsN = 1'b1; tick(4);
    check("R6 hold mid char", txAllowed, 1'b1);
    check("R10 disabled irq", ctsIrq, 1'b0);
    pulseStop();
    check("R6 stop at boundary", txAllowed, 1'b0);
    ctsN = 1'b0; tick(4);
    check("R8 wait boundary", txAllowed, 1'b0);
    pulseStop();
    check("R8 resume", txAllowed, 1'b1);
  endtask

  task automatic testCtsIdle();
    txIdle = 1'b1; ctsN = 1'b1; tick(2);
    check("R7 before third edge", txAllowed, 1'b1);
    tick(1);
    check("R7 third edge", txAllowed, 1'b0);
    ctsN = 1'b0; tick(3);
    check("R8 idle resume", txAllowed, 1'b1);
  endtask

  task automatic testCtsDisabled();
    autoCtsEn = 1'b0; ctsIntEn = 1'b1; txIdle = 1'b1;
    ctsN = 1'b1; tick(4);
    check("R9 no gate", txAllowed, 1'b1);
    check("R9 no irq", ctsIrq, 1'b0);
    ctsN = 1'b0; tick(4);
  endtask

  task automatic testIrq();
    autoCtsEn = 1'b1; ctsIntEn = 1'b1; txIdle = 1'b0;
    ctsN = 1'b1; tick(3);
    check("R10 set", ctsIrq, 1'b1);
    tick(3);
    check("R10 sticky", ctsIrq, 1'b1);
    ctsIrqAck = 1'b1; tick(1); ctsIrqAck = 1'b0;
    check("R10 ack", ctsIrq, 1'b0);
    ctsN = 1'b0; txIdle = 1'b1; tick(4);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testRtsMarks();
    testRtsSoftware();
    testCtsBusy();
    testCtsIdle();
    testCtsDisabled();
    testIrq();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule